// File: doc/BRIEF.md
# Dual-Processor Byte Handshake Link

This block joins a local microcontroller bus to a neighbouring processor through two one-byte channels, one per direction. Toward the local CPU it looks like four byte registers: a control register, the received byte, the byte to send and a status byte. Toward the peer it offers a data bus in each direction and two handshake pairs. Each pair is a strobe or acknowledge input from the peer and a level output that tells the peer where the handshake stands.

In the receive channel the peer places a byte on its data bus and raises a strobe. The synchronized rising edge of that strobe captures the byte and moves the receive state machine from `RX_EMPTY` to `RX_FULL`. In `RX_FULL` the ready line tells the peer to hold off, and an active-low line interrupts the local CPU. Software reads the byte. It then re-arms the channel by taking control bit 0 from 0 to 1, which is transition `RX_RELEASE` back to `RX_EMPTY`. A strobe edge in `RX_EMPTY` is transition `RX_CAPTURE`. A strobe edge in `RX_FULL` is transition `RX_OVERWRITE`: the state stays `RX_FULL` and the new byte replaces the old one.

In the transmit channel the state machine starts in `TX_ARMED`, where the request output to the peer is low. A synchronized rising edge on the peer's acknowledge input is transition `TX_COMPLETE`, which moves it to `TX_SENT`. Software polls the status register for that change, writes the next byte to the output latch, and re-arms the channel by taking control bit 1 from 0 to 1. That is transition `TX_REARM` back to `TX_ARMED`. When a software action and a peer edge reach the same state machine in the same clock cycle, the software action wins.

Top module: `peer_byte_link`

## Requirements
- R1: Register offsets are 0 for control, 1 for the received byte, 2 for the byte to send, and 3 for status. A read returns data combinationally from `bus_addr`. Control reads back the last value written to it. Offset 1 returns the received byte. Offset 2 reads as 0. Status has the transmit flag (1 in `TX_ARMED`) in bit 0 and zeros in the other bits.
- R2: After reset, `peer_ready` is 0, `cpu_irq_n` is 1, `tx_req_n` is 0, `tx_data` is 0, the received byte reads 0, control reads 0 and status reads 1.
- R3: A rising edge on `peer_stb` passes through a two-flop synchronizer. On the third clock edge after the strobe is first seen high, `peer_data` is captured, `peer_ready` goes to 1 and `cpu_irq_n` goes to 0.
- R4: A control write whose bit 0 is 1, while the stored control bit 0 is 0, returns the receive channel to `RX_EMPTY` on that clock edge (`peer_ready` 0, `cpu_irq_n` 1). A write of bit 0 = 1 while the stored bit 0 is already 1 has no effect on the receive channel.
- R5: A control write whose bit 1 is 1, while the stored control bit 1 is 0, puts the transmit channel in `TX_ARMED` on that edge: `tx_req_n` goes to 0 and status bit 0 reads 1.
- R6: A synchronized rising edge on `peer_ack` moves the transmit channel from `TX_ARMED` to `TX_SENT`: `tx_req_n` goes to 1 and status bit 0 reads 0.
- R7: A write to offset 2 loads `tx_data` on that clock edge. Writes to other offsets leave `tx_data` unchanged.
- R8: If a software release or re-arm and a synchronized peer edge reach the same channel in the same cycle, the software action decides the next state.
- R9: The received byte holds until the next strobe edge. A second strobe edge while in `RX_FULL` replaces the byte and the channel stays in `RX_FULL`.
- R10: A strobe held high gives only one capture. After a release, the channel stays in `RX_EMPTY` for as long as the strobe level stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Local bus access select |
| bus_wr | input | 1 | Write qualifier for the selected access |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| peer_data | input | DATA_W | Byte driven by the peer |
| peer_stb | input | 1 | Peer byte strobe, active on its rising edge |
| peer_ready | output | 1 | High while a received byte awaits software; low means ready to accept a byte |
| cpu_irq_n | output | 1 | Active-low data-available interrupt to the local CPU |
| peer_ack | input | 1 | Peer acknowledge, active on its rising edge |
| tx_req_n | output | 1 | Transmit request to the peer, low while armed |
| tx_data | output | DATA_W | Output byte latch |

## Verification
The collision of interest is a software release or re-arm landing in the same cycle as a synchronized peer edge on the same channel. The bench raises the strobe or the acknowledge, waits exactly two clock edges so that the synchronized edge is present in the next cycle, and issues the control write in that cycle. It then checks that the receive channel stays empty, or that the transmit channel ends up armed, instead of following the peer. The checker judges every such cycle by deciding the expected next state from the software event first.

// File: rtl/pbl_pkg.sv
package pbl_pkg;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_RXDATA = 2'd1,
        REG_TXDATA = 2'd2,
        REG_STATUS = 2'd3
    } reg_sel_e;

    typedef enum logic {
        RX_EMPTY = 1'b0,
        RX_FULL  = 1'b1
    } rx_state_e;

    typedef enum logic {
        TX_SENT  = 1'b0,
        TX_ARMED = 1'b1
    } tx_state_e;

    localparam int CTRL_RELEASE_BIT = 0;
    localparam int CTRL_REARM_BIT   = 1;
    localparam int STAT_TXFLAG_BIT  = 0;

endpackage

// File: rtl/pbl_sync_edge.sv
module pbl_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[LAST];
    end

    assign rise = chain_q[LAST] & ~prev_q;

endmodule

// File: rtl/pbl_bus_regs.sv
module pbl_bus_regs
    import pbl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              tx_flag,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              sw_release,
    output logic              sw_rearm,
    output logic              tx_load
);

    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(REG_CTRL);
    localparam logic [ADDR_W-1:0] A_RXDATA = ADDR_W'(REG_RXDATA);
    localparam logic [ADDR_W-1:0] A_TXDATA = ADDR_W'(REG_TXDATA);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);

    logic wr_en;
    logic ctrl_wr;

    assign wr_en   = bus_sel & bus_wr;
    assign ctrl_wr = wr_en && (bus_addr == A_CTRL);
    assign tx_load = wr_en && (bus_addr == A_TXDATA);

    // Software events fire on a 0->1 change of a control bit.
    assign sw_release = ctrl_wr & bus_wdata[CTRL_RELEASE_BIT] & ~ctrl_q[CTRL_RELEASE_BIT];
    assign sw_rearm   = ctrl_wr & bus_wdata[CTRL_REARM_BIT]   & ~ctrl_q[CTRL_REARM_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= bus_wdata;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL:   bus_rdata = ctrl_q;
            A_RXDATA: bus_rdata = rx_byte;
            A_STATUS: bus_rdata[STAT_TXFLAG_BIT] = tx_flag;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pbl_rx_chan.sv
module pbl_rx_chan
    import pbl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_rise,
    input  logic              sw_release,
    input  logic [DATA_W-1:0] peer_data,
    output logic [DATA_W-1:0] rx_byte,
    output logic              peer_ready,
    output logic              cpu_irq_n
);

    rx_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_EMPTY;
        else        state_q <= state_d;
    end

    // Release from software takes priority over a peer edge.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_EMPTY: if (!sw_release && stb_rise) state_d = RX_FULL;   // RX_CAPTURE
            RX_FULL:  if (sw_release)              state_d = RX_EMPTY;  // RX_RELEASE
            default:                               state_d = RX_EMPTY;
        endcase
    end

    always_comb begin
        peer_ready = 1'b0;
        cpu_irq_n  = 1'b1;
        unique case (state_q)
            RX_EMPTY: begin
                peer_ready = 1'b0;
                cpu_irq_n  = 1'b1;
            end
            RX_FULL: begin
                peer_ready = 1'b1;
                cpu_irq_n  = 1'b0;
            end
            default: begin
                peer_ready = 1'b0;
                cpu_irq_n  = 1'b1;
            end
        endcase
    end

    // Byte latch follows every synchronized strobe edge (RX_OVERWRITE included).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rx_byte <= '0;
        else if (stb_rise) rx_byte <= peer_data;
    end

endmodule

// File: rtl/pbl_tx_chan.sv
module pbl_tx_chan
    import pbl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_rise,
    input  logic              sw_rearm,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_flag,
    output logic              tx_req_n
);

    tx_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_ARMED;
        else        state_q <= state_d;
    end

    // Re-arm from software takes priority over a peer acknowledge.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_ARMED: if (!sw_rearm && ack_rise) state_d = TX_SENT;   // TX_COMPLETE
            TX_SENT:  if (sw_rearm)              state_d = TX_ARMED;  // TX_REARM
            default:                             state_d = TX_ARMED;
        endcase
    end

    always_comb begin
        tx_flag  = 1'b1;
        tx_req_n = 1'b0;
        unique case (state_q)
            TX_ARMED: begin
                tx_flag  = 1'b1;
                tx_req_n = 1'b0;
            end
            TX_SENT: begin
                tx_flag  = 1'b0;
                tx_req_n = 1'b1;
            end
            default: begin
                tx_flag  = 1'b1;
                tx_req_n = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tx_data <= '0;
        else if (tx_load) tx_data <= wdata;
    end

endmodule

// File: rtl/peer_byte_link.sv
module peer_byte_link
    import pbl_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] peer_data,
    input  logic              peer_stb,
    output logic              peer_ready,
    output logic              cpu_irq_n,
    input  logic              peer_ack,
    output logic              tx_req_n,
    output logic [DATA_W-1:0] tx_data
);

    logic              stb_rise;
    logic              ack_rise;
    logic              sw_release;
    logic              sw_rearm;
    logic              tx_load;
    logic              tx_flag;
    logic [DATA_W-1:0] rx_byte;
    logic [DATA_W-1:0] ctrl_q;

    pbl_sync_edge #(.STAGES(SYNC_STAGES)) u_stb_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (peer_stb),
        .rise     (stb_rise)
    );

    pbl_sync_edge #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (peer_ack),
        .rise     (ack_rise)
    );

    pbl_bus_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .rx_byte    (rx_byte),
        .tx_flag    (tx_flag),
        .ctrl_q     (ctrl_q),
        .sw_release (sw_release),
        .sw_rearm   (sw_rearm),
        .tx_load    (tx_load)
    );

    pbl_rx_chan #(.DATA_W(DATA_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb_rise   (stb_rise),
        .sw_release (sw_release),
        .peer_data  (peer_data),
        .rx_byte    (rx_byte),
        .peer_ready (peer_ready),
        .cpu_irq_n  (cpu_irq_n)
    );

    pbl_tx_chan #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_rise (ack_rise),
        .sw_rearm (sw_rearm),
        .tx_load  (tx_load),
        .wdata    (bus_wdata),
        .tx_data  (tx_data),
        .tx_flag  (tx_flag),
        .tx_req_n (tx_req_n)
    );

endmodule

// File: rtl/pbl_checker.sv
module pbl_checker #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] ctrl_q,
    input logic              stb_rise,
    input logic              ack_rise,
    input logic [DATA_W-1:0] rx_byte,
    input logic              peer_ready,
    input logic              cpu_irq_n,
    input logic              tx_req_n,
    input logic [DATA_W-1:0] tx_data
);

    logic wr_ctrl, wr_tx, rel_ev, arm_ev;

    assign wr_ctrl = bus_sel && bus_wr && (bus_addr == ADDR_W'(0));
    assign wr_tx   = bus_sel && bus_wr && (bus_addr == ADDR_W'(2));
    assign rel_ev  = wr_ctrl && bus_wdata[0] && !ctrl_q[0];
    assign arm_ev  = wr_ctrl && bus_wdata[1] && !ctrl_q[1];

    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stb_rise && !rel_ev |=> peer_ready && !cpu_irq_n);

    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rel_ev |=> !peer_ready && cpu_irq_n);

    p_rearm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arm_ev |=> !tx_req_n);

    p_complete_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rise && !arm_ev |=> tx_req_n);

    p_txload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tx |=> tx_data == $past(bus_wdata));

    p_txhold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_tx |=> $stable(tx_data));

    p_sw_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rel_ev && stb_rise |=> !peer_ready);

    p_rxhold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_rise |=> $stable(rx_byte));

    p_rxquiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_rise && !rel_ev |=> $stable(peer_ready));

    p_txquiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_rise && !arm_ev |=> $stable(tx_req_n));

endmodule

bind peer_byte_link pbl_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .ctrl_q     (ctrl_q),
    .stb_rise   (stb_rise),
    .ack_rise   (ack_rise),
    .rx_byte    (rx_byte),
    .peer_ready (peer_ready),
    .cpu_irq_n  (cpu_irq_n),
    .tx_req_n   (tx_req_n),
    .tx_data    (tx_data)
);

// File: tb/peer_byte_link_tb.sv
module peer_byte_link_tb;

    localparam int CLK_NS = 10;
    localparam int NVEC   = 6;
    // Each entry: {byte sent by peer, byte written by software}
    localparam logic [15:0] VEC [NVEC] = '{16'h5A3C, 16'h00FF, 16'hFF00,
                                           16'hA5C3, 16'h0180, 16'h7E81};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [7:0] peer_data = 8'd0;
    logic       peer_stb = 1'b0;
    logic       peer_ready;
    logic       cpu_irq_n;
    logic       peer_ack = 1'b0;
    logic       tx_req_n;
    logic [7:0] tx_data;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] rd;

    always #(CLK_NS/2) clk = ~clk;

    peer_byte_link u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .peer_data(peer_data), .peer_stb(peer_stb), .peer_ready(peer_ready),
        .cpu_irq_n(cpu_irq_n), .peer_ack(peer_ack), .tx_req_n(tx_req_n),
        .tx_data(tx_data)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic send_strobe(input logic [7:0] d);
        @(negedge clk);
        peer_data = d; peer_stb = 1'b1;
        repeat (3) @(negedge clk);
        peer_stb = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_ack();
        @(negedge clk);
        peer_ack = 1'b1;
        repeat (3) @(negedge clk);
        peer_ack = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic release_rx();
        bus_write(2'd0, 8'h00);
        bus_write(2'd0, 8'h01);
    endtask

    task automatic rearm_tx();
        bus_write(2'd0, 8'h02);
        bus_write(2'd0, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        check("R2 peer_ready", {7'd0, peer_ready}, 8'd0);
        check("R2 cpu_irq_n", {7'd0, cpu_irq_n}, 8'd1);
        check("R2 tx_req_n", {7'd0, tx_req_n}, 8'd0);
        check("R2 tx_data", tx_data, 8'd0);
        bus_read(2'd1, rd); check("R2 rx byte", rd, 8'd0);
        bus_read(2'd0, rd); check("R2 ctrl", rd, 8'd0);
        bus_read(2'd3, rd); check("R2 status", rd, 8'd1);

        // Table-driven traffic in both directions
        for (int i = 0; i < NVEC; i++) begin
            send_strobe(VEC[i][15:8]);
            check("R3 ready set", {7'd0, peer_ready}, 8'd1);
            check("R3 irq low", {7'd0, cpu_irq_n}, 8'd0);
            bus_read(2'd1, rd); check("R1 R3 rx byte", rd, VEC[i][15:8]);
            release_rx();
            check("R4 ready cleared", {7'd0, peer_ready}, 8'd0);
            check("R4 irq high", {7'd0, cpu_irq_n}, 8'd1);
            bus_read(2'd1, rd); check("R9 rx byte held", rd, VEC[i][15:8]);
            bus_read(2'd0, rd); check("R1 ctrl readback", rd, 8'h01);

            bus_write(2'd2, VEC[i][7:0]);
            check("R7 tx_data load", tx_data, VEC[i][7:0]);
            bus_read(2'd2, rd); check("R1 txdata reads zero", rd, 8'd0);
            send_ack();
            check("R6 tx_req_n high", {7'd0, tx_req_n}, 8'd1);
            bus_read(2'd3, rd); check("R6 status", rd, 8'd0);
            rearm_tx();
            check("R5 tx_req_n low", {7'd0, tx_req_n}, 8'd0);
            bus_read(2'd3, rd); check("R5 status", rd, 8'd1);
            check("R7 tx_data held", tx_data, VEC[i][7:0]);
        end

        // R7: writes elsewhere leave tx_data alone
        bus_write(2'd3, 8'h99);
        bus_write(2'd1, 8'h66);
        check("R7 tx_data unaffected", tx_data, VEC[NVEC-1][7:0]);

        // R4: repeat write of bit0=1 when already 1 does nothing
        bus_write(2'd0, 8'h01);
        send_strobe(8'h3C);
        bus_write(2'd0, 8'h01);
        check("R4 no release without 0->1", {7'd0, peer_ready}, 8'd1);

        // R9: second strobe while full overwrites and stays full
        send_strobe(8'hC4);
        bus_read(2'd1, rd); check("R9 overwrite byte", rd, 8'hC4);
        check("R9 still full", {7'd0, peer_ready}, 8'd1);
        release_rx();
        check("R4 release", {7'd0, peer_ready}, 8'd0);

        // R10: strobe held high gives one capture only
        @(negedge clk);
        peer_data = 8'h11; peer_stb = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 captured", {7'd0, peer_ready}, 8'd1);
        release_rx();
        repeat (4) @(negedge clk);
        check("R10 level ignored", {7'd0, peer_ready}, 8'd0);
        peer_stb = 1'b0;
        repeat (3) @(negedge clk);

        // R8: release coincides with synchronized strobe edge
        bus_write(2'd0, 8'h00);
        @(negedge clk);
        peer_data = 8'h77; peer_stb = 1'b1;
        repeat (2) @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h01;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        check("R8 release wins", {7'd0, peer_ready}, 8'd0);
        repeat (3) @(negedge clk);
        check("R8 stays empty", {7'd0, cpu_irq_n}, 8'd1);
        peer_stb = 1'b0;
        repeat (3) @(negedge clk);

        // R8: re-arm coincides with synchronized acknowledge edge
        send_ack();
        check("R6 sent", {7'd0, tx_req_n}, 8'd1);
        bus_write(2'd0, 8'h00);
        @(negedge clk);
        peer_ack = 1'b1;
        repeat (2) @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h02;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        check("R8 rearm wins", {7'd0, tx_req_n}, 8'd0);
        repeat (3) @(negedge clk);
        bus_read(2'd3, rd); check("R8 still armed", rd, 8'd1);
        peer_ack = 1'b0;
        repeat (3) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule